// File: doc/BRIEF.md
# Cyclic DAC Playback Buffer

This block is a dual-clock sample store that sits between a stream source (a DMA engine or an unpacker) and a DAC. In the source clock it takes in one beat of multi-channel sample data per valid cycle, but only while a transfer request is held high. Each new request starts storing from the first location again. When the request drops, the block records the last location it filled as the end of the waveform. It then passes that end location to the DAC clock.

In the DAC clock a read pointer advances by one location on every cycle. After it reaches the recorded end it returns to the first location, so the stored waveform plays out to the DAC in an endless loop. The output stays at zero until the first transfer has stored at least one beat. A new end location restarts playback at the first location.

Top module: `cyclic_play_buf`

## Requirements
- R1: After either reset, and until a request has completed with at least one stored beat, `dac_data` is all zeros.
- R2: A beat with `src_valid` high while `src_req` is low is not stored. Stored contents and playback are unchanged, even when the write pointer points at a location inside the playback loop.
- R3: During a request, each beat with `src_valid` high is stored at the next location in order. Cycles with `src_valid` low inside the request neither store nor advance the location.
- R4: The first beat after `src_req` rises is stored at location 0, whatever the previous transfer left behind. This holds whether that beat arrives in the rising cycle itself or later.
- R5: When `src_req` falls, the location of the last stored beat becomes the loop end. A transfer of N beats plays back as a loop of exactly N samples, and N = 1 gives a constant output.
- R6: Once a new loop end reaches the DAC clock, playback restarts at location 0. It then presents one new stored beat per `dac_clk` cycle, in storage order, and wraps from the end location back to location 0.
- R7: A request that ends with no stored beat leaves the loop end and the playback unchanged.
- R8: A transfer that fills every location (2^ADDR_W beats) plays back all of them. Each beat is CHANNELS lanes of SAMPLE_W bits, and lane c occupies bits [c*SAMPLE_W +: SAMPLE_W]. Every lane is kept intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source (write) clock |
| src_rst | input | 1 | Active-high synchronous reset, source domain |
| src_req | input | 1 | Transfer request; beats are stored only while high |
| src_valid | input | 1 | Beat qualifier for `src_data` |
| src_data | input | CHANNELS*SAMPLE_W | Multi-channel sample beat |
| dac_clk | input | 1 | DAC (read) clock |
| dac_rst | input | 1 | Active-high synchronous reset, DAC domain |
| dac_data | output | CHANNELS*SAMPLE_W | Looped playback sample toward the DAC |

## Verification
A table of transfers drives the store. Each transfer has its own length, its own placement of idle cycles inside the request and its own data base. Gapless, gapped, single-beat and mid-length transfers show whether idle cycles advance the pointer, whether an idle rising cycle still restarts at location 0, and whether the loop end tracks the beat count. A short transfer that follows a long one separates a true restart at location 0 from a pointer that carries on from the previous transfer. Directed cases cover a full-depth fill, in which stray beats outside a request would land inside the loop, an empty request, and a reset in the middle of playback.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
   // Phase of the transfer request, formed from {previous, current}
   typedef enum logic [1:0] {
      REQ_IDLE  = 2'b00,
      REQ_START = 2'b01,
      REQ_END   = 2'b10,
      REQ_BUSY  = 2'b11
   } req_phase_e;

   localparam int MIN_SYNC_STAGES = 2;
   localparam int MIN_ADDR_W      = 1;
endpackage

// File: rtl/cpb_wr_ctrl.sv
module cpb_wr_ctrl
   import cpb_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              valid,
   input  logic [DATA_W-1:0] din,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_din,
   output logic [ADDR_W-1:0] end_addr,
   output logic              end_tgl
);
   logic              req_q;
   logic              wrote;
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] last_addr;
   req_phase_e        phase;

   assign phase    = req_phase_e'({req_q, req});
   assign eff_addr = (phase == REQ_START) ? '0 : waddr;
   assign mem_we   = req & valid;
   assign mem_addr = eff_addr;
   assign mem_din  = din;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q     <= 1'b0;
         waddr     <= '0;
         last_addr <= '0;
         wrote     <= 1'b0;
         end_addr  <= '0;
         end_tgl   <= 1'b0;
      end else begin
         req_q <= req;
         if (mem_we) begin
            waddr     <= eff_addr + ADDR_W'(1);
            last_addr <= eff_addr;
         end else if (phase == REQ_START) begin
            waddr <= '0;
         end
         if (phase == REQ_START) begin
            wrote <= mem_we;
         end else if (mem_we) begin
            wrote <= 1'b1;
         end
         if (phase == REQ_END && wrote) begin
            end_addr <= last_addr;
            end_tgl  <= ~end_tgl;
         end
      end
   end

   // R2: outside a request the write pointer never moves
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !req |=> $stable(waddr));
   // R4: a beat in the rising cycle lands at location 0, pointer then at 1
   p_restart_r4: assert property (@(posedge clk) disable iff (rst)
      (req && !req_q && valid) |=> (waddr == ADDR_W'(1)));
   // R3: an accepted beat inside a running request advances by one
   p_incr_r3: assert property (@(posedge clk) disable iff (rst)
      (req && req_q && valid) |=> (waddr == $past(waddr) + ADDR_W'(1)));
   // R5/R7: loop end follows the last stored location only when something was stored
   p_end_r5: assert property (@(posedge clk) disable iff (rst)
      (req_q && !req && wrote) |=> (end_addr == $past(last_addr)));
   p_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (req_q && !req && !wrote) |=> $stable(end_tgl));
endmodule

// File: rtl/cpb_mem.sv
module cpb_mem #(
   parameter int CHANNELS = 2,
   parameter int SAMPLE_W = 16,
   parameter int ADDR_W   = 5,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                         wclk,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            waddr,
   input  logic [CHANNELS*SAMPLE_W-1:0] wdata,
   input  logic                         rclk,
   input  logic                         rrst,
   input  logic                         re,
   input  logic [ADDR_W-1:0]            raddr,
   output logic [CHANNELS*SAMPLE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
      logic [SAMPLE_W-1:0] bank [DEPTH];
      logic [SAMPLE_W-1:0] rd_q;

      always_ff @(posedge wclk) begin
         if (we) bank[waddr] <= wdata[ch*SAMPLE_W +: SAMPLE_W];
      end

      always_ff @(posedge rclk) begin
         if (rrst)    rd_q <= '0;
         else if (re) rd_q <= bank[raddr];
         else         rd_q <= '0;
      end

      if (OUT_REG) begin : g_oreg
         logic [SAMPLE_W-1:0] out_q;
         always_ff @(posedge rclk) begin
            if (rrst) out_q <= '0;
            else      out_q <= rd_q;
         end
         assign rdata[ch*SAMPLE_W +: SAMPLE_W] = out_q;
      end else begin : g_direct
         assign rdata[ch*SAMPLE_W +: SAMPLE_W] = rd_q;
      end
   end
endmodule

// File: rtl/cpb_end_sync.sv
module cpb_end_sync #(
   parameter int ADDR_W = 5,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tgl_in,
   input  logic [ADDR_W-1:0] end_in,
   output logic              arrive,
   output logic [ADDR_W-1:0] end_out
);
   logic [STAGES:0] chain;

   assign arrive = chain[STAGES] ^ chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         chain   <= '0;
         end_out <= '0;
      end else begin
         chain <= {chain[STAGES-1:0], tgl_in};
         if (arrive) end_out <= end_in;
      end
   end

   // R6: one source toggle yields a single-cycle arrival pulse
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      arrive |=> !arrive);
endmodule

// File: rtl/cpb_rd_ctrl.sv
module cpb_rd_ctrl #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              new_end,
   input  logic [ADDR_W-1:0] end_addr,
   output logic              armed,
   output logic [ADDR_W-1:0] raddr
);
   always_ff @(posedge clk) begin
      if (rst) begin
         raddr <= '0;
         armed <= 1'b0;
      end else if (new_end) begin
         raddr <= '0;
         armed <= 1'b1;
      end else if (armed) begin
         raddr <= (raddr == end_addr) ? '0 : raddr + ADDR_W'(1);
      end
   end

   // R1: nothing is played before the first loop end arrives
   p_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !armed |-> (raddr == '0));
   // R6: a fresh loop end restarts at location 0
   p_restart_r6: assert property (@(posedge clk) disable iff (rst)
      new_end |=> (armed && raddr == '0));
   // R5: wrap after the end location
   p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (armed && !new_end && raddr == end_addr) |=> (raddr == '0));
   // R6: one step per cycle below the end
   p_step_r6: assert property (@(posedge clk) disable iff (rst)
      (armed && !new_end && raddr != end_addr) |=> (raddr == $past(raddr) + ADDR_W'(1)));
endmodule

// File: rtl/cyclic_play_buf.sv
module cyclic_play_buf
   import cpb_pkg::*;
#(
   parameter int CHANNELS    = 2,
   parameter int SAMPLE_W    = 16,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic                         src_clk,
   input  logic                         src_rst,
   input  logic                         src_req,
   input  logic                         src_valid,
   input  logic [CHANNELS*SAMPLE_W-1:0] src_data,
   input  logic                         dac_clk,
   input  logic                         dac_rst,
   output logic [CHANNELS*SAMPLE_W-1:0] dac_data
);
   localparam int DATA_W = CHANNELS * SAMPLE_W;

   if (CHANNELS < 1) begin : g_bad_ch
      $error("cyclic_play_buf: CHANNELS must be at least 1");
   end
   if (SAMPLE_W < 1) begin : g_bad_sw
      $error("cyclic_play_buf: SAMPLE_W must be at least 1");
   end
   if (ADDR_W < MIN_ADDR_W || ADDR_W > 16) begin : g_bad_aw
      $error("cyclic_play_buf: ADDR_W out of range");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("cyclic_play_buf: SYNC_STAGES below minimum");
   end

   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;
   logic [ADDR_W-1:0] src_end;
   logic              src_tgl;
   logic              dac_arrive;
   logic [ADDR_W-1:0] dac_end;
   logic              dac_armed;
   logic [ADDR_W-1:0] dac_raddr;

   cpb_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk      (src_clk),
      .rst      (src_rst),
      .req      (src_req),
      .valid    (src_valid),
      .din      (src_data),
      .mem_we   (mem_we),
      .mem_addr (mem_waddr),
      .mem_din  (mem_wdata),
      .end_addr (src_end),
      .end_tgl  (src_tgl)
   );

   cpb_end_sync #(.ADDR_W(ADDR_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (dac_clk),
      .rst     (dac_rst),
      .tgl_in  (src_tgl),
      .end_in  (src_end),
      .arrive  (dac_arrive),
      .end_out (dac_end)
   );

   cpb_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
      .clk      (dac_clk),
      .rst      (dac_rst),
      .new_end  (dac_arrive),
      .end_addr (dac_end),
      .armed    (dac_armed),
      .raddr    (dac_raddr)
   );

   cpb_mem #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_mem (
      .wclk  (src_clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .rclk  (dac_clk),
      .rrst  (dac_rst),
      .re    (dac_armed),
      .raddr (dac_raddr),
      .rdata (dac_data)
   );
endmodule

// File: tb/sim_cyclic_play_buf.sv
module sim_cyclic_play_buf;
   localparam int CH     = 2;
   localparam int SW     = 16;
   localparam int AW     = 5;
   localparam int DEPTH  = 1 << AW;
   localparam int DW     = CH * SW;

   // {length[21:16], idle-before-beat mask[15:8], data base[7:0]}
   localparam logic [21:0] VEC [5] = '{
      {6'd5,  8'b0000_0000, 8'h11},
      {6'd12, 8'b0101_0010, 8'h22},
      {6'd3,  8'b0000_0001, 8'h33},
      {6'd1,  8'b0000_0000, 8'h44},
      {6'd20, 8'b1000_0000, 8'h55}
   };

   logic          src_clk = 1'b0;
   logic          dac_clk = 1'b0;
   logic          src_rst = 1'b1;
   logic          dac_rst = 1'b1;
   logic          src_req = 1'b0;
   logic          src_valid = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic [DW-1:0] dac_data;

   int total = 0;
   int fails = 0;

   always #2.5 src_clk = ~src_clk;   // 200 MHz
   always #3.5 dac_clk = ~dac_clk;

   cyclic_play_buf #(.CHANNELS(CH), .SAMPLE_W(SW), .ADDR_W(AW)) u0 (
      .src_clk (src_clk), .src_rst (src_rst), .src_req (src_req),
      .src_valid (src_valid), .src_data (src_data),
      .dac_clk (dac_clk), .dac_rst (dac_rst), .dac_data (dac_data)
   );

   function automatic logic [DW-1:0] samp(input logic [7:0] base, input int idx);
      logic [DW-1:0] v;
      for (int c = 0; c < CH; c++) begin
         v[c*SW +: SW] = {base, 8'(idx + 1)} ^ (16'(c) << 12);
      end
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input int len, input logic [7:0] gaps, input logic [7:0] base);
      @(negedge src_clk);
      src_req = 1'b1;
      for (int i = 0; i < len; i++) begin
         if (gaps[i % 8]) begin
            src_valid = 1'b0;
            @(negedge src_clk);
         end
         src_valid = 1'b1;
         src_data  = samp(base, i);
         @(negedge src_clk);
      end
      src_valid = 1'b0;
      @(negedge src_clk);
      src_req = 1'b0;
      repeat (4) @(negedge src_clk);
   endtask

   // Find sample 0 of the loop, then compare two full passes
   task automatic check_loop(input int len, input logic [7:0] base, input string tag);
      bit found = 1'b0;
      bit ok1 = 1'b1;
      bit ok2 = 1'b1;
      logic [DW-1:0] a1 = '0, e1 = '0, a2 = '0, e2 = '0;
      for (int w = 0; w < 400 && !found; w++) begin
         @(negedge dac_clk);
         if (dac_data == samp(base, 0)) found = 1'b1;
      end
      check(found, {tag, " loop start"}, dac_data, samp(base, 0));
      if (!found) return;
      for (int k = 1; k <= 2 * len; k++) begin
         @(negedge dac_clk);
         if (dac_data != samp(base, k % len)) begin
            if (k < len && ok1) begin ok1 = 1'b0; a1 = dac_data; e1 = samp(base, k % len); end
            if (k >= len && ok2) begin ok2 = 1'b0; a2 = dac_data; e2 = samp(base, k % len); end
         end
      end
      check(ok1, {tag, " order"}, a1, e1);
      check(ok2, {tag, " wrap"}, a2, e2);
   endtask

   task automatic check_zero(input string tag);
      bit ok = 1'b1;
      logic [DW-1:0] a = '0;
      for (int k = 0; k < 40; k++) begin
         @(negedge dac_clk);
         if (dac_data != '0 && ok) begin ok = 1'b0; a = dac_data; end
      end
      check(ok, tag, a, '0);
   endtask

   task automatic do_reset();
      src_rst = 1'b1;
      dac_rst = 1'b1;
      repeat (5) @(negedge dac_clk);
      src_rst = 1'b0;
      dac_rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge src_clk);
      total++;
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      do_reset();
      // R1: idle output after reset
      check_zero("R1 zero after reset");

      // Table walk: R3 gaps, R4 restart after longer transfer, R5 single-beat loop, R6 stepping
      for (int v = 0; v < 5; v++) begin
         xfer(int'(VEC[v][21:16]), VEC[v][15:8], VEC[v][7:0]);
         check_loop(int'(VEC[v][21:16]), VEC[v][7:0], $sformatf("R3 R4 R5 R6 vec%0d", v));
      end

      // R8: full-depth fill, all lanes
      xfer(DEPTH, 8'b0000_0000, 8'h66);
      check_loop(DEPTH, 8'h66, "R8 full depth");

      // R2: stray beats outside a request, pointer now at location 0
      @(negedge src_clk);
      for (int k = 0; k < 40; k++) begin
         src_valid = 1'b1;
         src_data  = {DW{1'b1}} ^ DW'(k);
         @(negedge src_clk);
      end
      src_valid = 1'b0;
      repeat (20) @(negedge dac_clk);
      check_loop(DEPTH, 8'h66, "R2 ignored beats");

      // R7: request with no beats
      @(negedge src_clk);
      src_req = 1'b1;
      repeat (4) @(negedge src_clk);
      src_req = 1'b0;
      repeat (30) @(negedge dac_clk);
      check_loop(DEPTH, 8'h66, "R7 empty request");

      // R1: reset during playback returns output to zero
      do_reset();
      check_zero("R1 zero after mid reset");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule